// File: doc/BRIEF.md
# Thread-to-Warp Launch Packer

This block turns a flat kernel launch, given as a single thread count, into a stream of warp descriptors for a downstream warp scheduler. Threads are packed in ascending order into warps of 32 lanes. Each descriptor carries the warp's sequence number, the ID of its first thread, and a lane-active mask with one bit per lane. Every warp is full except possibly the last one. When the count is not a multiple of 32, that final warp gets a ragged mask in which only the low lanes are set.

A launch begins with a one-cycle `start` pulse while the block is idle. From the cycle after that pulse, two summary outputs are valid and stay held until the next accepted launch: the total number of warps, and the number of lanes that hold no thread. Descriptors leave one per cycle under a valid/ready handshake. A one-cycle `done` pulse follows the last accepted descriptor. A launch of zero threads produces no descriptors and pulses `done` at once.

Top module: `warp_launch_packer`

## Requirements
- R1: One cycle after an accepted `start`, `warp_total` equals the thread count divided by 32, rounded up. It holds that value until the next accepted `start`.
- R2: Over the same period, `idle_lanes` equals `warp_total`×32 minus the thread count. This value is 0 for an exact multiple of 32 and at most 31 otherwise.
- R3: Descriptors appear in order with `warp_idx` = 0, 1, 2, … and `base_tid` = 32×`warp_idx`. A new index appears only after the previous descriptor is accepted (`desc_valid` and `desc_ready` both high at a clock edge).
- R4: Every descriptor other than the ragged last one carries `lane_mask` = 0xFFFFFFFF. When the count is an exact multiple of 32, all descriptors do.
- R5: If the count mod 32 is r, with r not zero, the last descriptor's `lane_mask` has exactly bits [r-1:0] set. For example, 100 threads give 0x0000000F in warp 3, and 1 thread gives 0x00000001 with `idle_lanes` = 31.
- R6: A count of zero produces no descriptor. `done` is high in the cycle right after the `start` edge, and `warp_total` is 0.
- R7: While `desc_valid` is high and `desc_ready` is low, `desc_valid`, `warp_idx`, `base_tid` and `lane_mask` hold their values into the next cycle.
- R8: `busy` is high from the cycle after a non-zero `start` until the last descriptor is accepted. `done` is high for exactly the one cycle after that acceptance, with `desc_valid` low.
- R9: A `start` raised while `busy` is high is ignored. The totals and the descriptor sequence continue unchanged.
- R10: After reset, `desc_valid`, `busy` and `done` are low and `warp_total` and `idle_lanes` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, taken only while idle |
| thread_count | input | CNT_W (16) | Thread count sampled with `start` |
| busy | output | 1 | Descriptors still pending for this launch |
| done | output | 1 | One-cycle end-of-launch pulse |
| desc_valid | output | 1 | Descriptor fields are valid |
| desc_ready | input | 1 | Consumer accepts the descriptor |
| warp_idx | output | WARP_W (12) | Warp sequence number |
| base_tid | output | CNT_W (16) | ID of the thread in lane 0 |
| lane_mask | output | LANES (32) | Lane-active mask, bit i is lane i |
| warp_total | output | WARP_W (12) | Warps in the current launch |
| idle_lanes | output | log2(LANES) (5) | Masked lanes in the current launch |

## Verification
A corrupted warp counter shows up at the ports in the very next descriptor. It appears as a skipped or repeated `warp_idx` and a matching `base_tid` error, so the bench compares every descriptor against an independently computed index and base. A wrong tail or total register shows up only in the last descriptor's mask, in `idle_lanes`, or in the timing of `done`. The bench therefore mixes random counts, both ragged and exact, with directed counts of 0, 1, 31, 32, 33, 100 and the maximum. Random back-pressure exposes fields that drift while stalled, within one cycle of the stall.

// File: rtl/wlp_pkg.sv
// Shared types for the warp launch packer.
package wlp_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_EMIT} wlp_state_e;
endpackage

// File: rtl/wlp_sizer.sv
// Launch sizer: on load, captures the warp count, the tail lane count and the
// idle-lane count for a thread count. Assumes LANES is a power of two.
module wlp_sizer #(
    parameter int LANES = 32,
    parameter int CNT_W = 16,
    localparam int LB   = $clog2(LANES),
    localparam int WW   = CNT_W - LB + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CNT_W-1:0] count,
    output logic [WW-1:0] warps_q,
    output logic [LB-1:0] tail_q,
    output logic [LB-1:0] idle_q
);
    logic [CNT_W:0]  rounded;
    logic [WW-1:0]   warps_c;
    logic [LB-1:0]   tail_c;
    logic [LB-1:0]   idle_c;

    // Round the count up to whole warps and find the leftover lanes.
    always_comb begin
        rounded = {1'b0, count} + (CNT_W+1)'(LANES - 1);
        warps_c = WW'(rounded >> LB);
        tail_c  = count[LB-1:0];
        idle_c  = (tail_c == '0) ? '0 : LB'(LANES - int'(tail_c));
    end

    // Hold the launch totals until the next accepted launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warps_q <= '0;
            tail_q  <= '0;
            idle_q  <= '0;
        end else if (load) begin
            warps_q <= warps_c;
            tail_q  <= tail_c;
            idle_q  <= idle_c;
        end
    end

    // R2: idle lanes and tail lanes add up to a whole warp when a tail exists
    p_idle_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q != '0) |-> (int'(idle_q) + int'(tail_q) == LANES));
endmodule

// File: rtl/wlp_lane_mask.sv
// Lane mask generator: sets the lowest `active` lanes. Assumes active <= LANES.
module wlp_lane_mask #(
    parameter int LANES = 32,
    localparam int LB   = $clog2(LANES)
) (
    input  logic [LB:0]      active,
    output logic [LANES-1:0] mask
);
    // One comparator per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = ((LB+1)'(i) < active);
    end

    // R5: active lanes always form a contiguous run from lane 0
    always_comb begin
        p_contig_r5: assert ((mask & (mask + 1'b1)) == '0);
    end
endmodule

// File: rtl/wlp_sequencer.sv
// Descriptor sequencer: steps the warp index under valid/ready and pulses done.
// Assumes is_last is computed from the totals captured at the same start edge.
module wlp_sequencer #(
    parameter int WW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cnt_zero,
    input  logic          is_last,
    input  logic          ready,
    output logic          valid,
    output logic          busy,
    output logic          done,
    output logic          accept_start,
    output logic [WW-1:0] idx
);
    import wlp_pkg::*;
    wlp_state_e state;

    assign valid        = (state == ST_EMIT);
    assign busy         = valid;
    assign accept_start = start && (state == ST_IDLE);

    // Launch, step and finish control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    idx <= '0;
                    if (cnt_zero) done  <= 1'b1;
                    else          state <= ST_EMIT;
                end
                ST_EMIT: if (ready) begin
                    if (is_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: an accepted non-final descriptor is followed by the next index
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !is_last) |=> (valid && idx == $past(idx) + 1'b1));
    // R8: done never overlaps a pending descriptor
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid);
    // R8: the final acceptance ends the launch with a done pulse
    p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && is_last) |=> (done && !busy));
endmodule

// File: rtl/warp_launch_packer.sv
// Thread-to-warp launch packer: splits a thread count into 32-lane warp
// descriptors (index, base thread, lane mask), one per accepted handshake.
// Assumes start is only honoured while idle; totals hold until the next launch.
module warp_launch_packer #(
    parameter int LANES = 32,
    parameter int CNT_W = 16,
    localparam int LB   = $clog2(LANES),
    localparam int WW   = CNT_W - LB + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] thread_count,
    output logic             busy,
    output logic             done,
    output logic             desc_valid,
    input  logic             desc_ready,
    output logic [WW-1:0]    warp_idx,
    output logic [CNT_W-1:0] base_tid,
    output logic [LANES-1:0] lane_mask,
    output logic [WW-1:0]    warp_total,
    output logic [LB-1:0]    idle_lanes
);
    logic          load;
    logic [LB-1:0] tail;
    logic          is_last;
    logic [LB:0]   active;

    wlp_sizer #(.LANES(LANES), .CNT_W(CNT_W)) u_sizer (
        .clk(clk), .rst_n(rst_n), .load(load), .count(thread_count),
        .warps_q(warp_total), .tail_q(tail), .idle_q(idle_lanes)
    );

    wlp_sequencer #(.WW(WW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cnt_zero(thread_count == '0), .is_last(is_last), .ready(desc_ready),
        .valid(desc_valid), .busy(busy), .done(done),
        .accept_start(load), .idx(warp_idx)
    );

    // Select the full-warp or ragged-tail lane count for the current warp.
    always_comb begin
        is_last = (warp_idx == warp_total - 1'b1);
        active  = (is_last && tail != '0) ? {1'b0, tail} : (LB+1)'(LANES);
    end

    wlp_lane_mask #(.LANES(LANES)) u_mask (.active(active), .mask(lane_mask));

    // Base thread of a warp is its index scaled by the warp width.
    assign base_tid = CNT_W'({warp_idx, {LB{1'b0}}});

    // R7: a stalled descriptor holds all its fields
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(warp_idx)
            && $stable(base_tid) && $stable(lane_mask)));
    // R5: the last mask plus the idle lanes fill exactly one warp
    p_tail_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && is_last) |-> ($countones(lane_mask) + int'(idle_lanes) == LANES));
    // R4: non-final warps are fully populated
    p_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !is_last) |-> (lane_mask == '1));
    // R9: a start during a launch leaves the totals untouched
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(warp_total));
endmodule

// File: tb/warp_launch_packer_test.sv
`timescale 1ns/100ps
module warp_launch_packer_test;
    localparam int LANES = 32;
    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] thread_count = '0;
    logic        desc_ready = 1'b0;
    logic        busy, done, desc_valid;
    logic [11:0] warp_idx, warp_total;
    logic [15:0] base_tid;
    logic [31:0] lane_mask;
    logic [4:0]  idle_lanes;

    int checks = 0;
    int errors = 0;

    warp_launch_packer #(.LANES(LANES), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .thread_count(thread_count),
        .busy(busy), .done(done), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .warp_idx(warp_idx), .base_tid(base_tid), .lane_mask(lane_mask),
        .warp_total(warp_total), .idle_lanes(idle_lanes)
    );

    always #2.5 clk = ~clk;

    function automatic int exp_warps(input int n);
        return (n + 31) / 32;
    endfunction
    function automatic int exp_idle(input int n);
        return exp_warps(n) * 32 - n;
    endfunction
    function automatic logic [31:0] exp_mask(input int n, input int k);
        if (k < exp_warps(n) - 1 || n % 32 == 0) return 32'hFFFF_FFFF;
        return (32'h1 << (n % 32)) - 32'h1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One launch of n threads with random back-pressure; optional start injection.
    task automatic launch(input int n, input int stall_pct, input bit inject);
        int nw = exp_warps(n);
        int k = 0;
        bit injected = 1'b0;
        bit stalled = 1'b0;
        logic [31:0] pm;
        logic [15:0] pb;
        start = 1'b1; thread_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
        chk(warp_total == 12'(nw), "R1", "warp_total", warp_total, nw);
        chk(idle_lanes == 5'(exp_idle(n)), "R2", "idle_lanes", idle_lanes, exp_idle(n));
        if (n == 0) begin
            chk(done && !desc_valid, "R6", "zero-count done/valid", {done, desc_valid}, 2'b10);
            @(negedge clk);
            chk(!done && !desc_valid, "R6", "zero-count quiet", {done, desc_valid}, 0);
            return;
        end
        chk(busy, "R8", "busy after start", busy, 1);
        while (k < nw) begin
            chk(desc_valid, "R3", "desc_valid", desc_valid, 1);
            chk(warp_idx == 12'(k), "R3", "warp_idx", warp_idx, k);
            chk(base_tid == 16'(k * 32), "R3", "base_tid", base_tid, k * 32);
            chk(lane_mask == exp_mask(n, k), (k == nw - 1 && n % 32 != 0) ? "R5" : "R4",
                "lane_mask", lane_mask, exp_mask(n, k));
            if (stalled)
                chk(lane_mask == pm && base_tid == pb, "R7", "held fields",
                    {base_tid, lane_mask}, {pb, pm});
            desc_ready = (int'($urandom % 100) >= stall_pct);
            stalled = !desc_ready; pm = lane_mask; pb = base_tid;
            if (inject && !injected && k == 1) begin
                start = 1'b1; thread_count = 16'd7; injected = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (desc_ready) k++;
        end
        desc_ready = 1'b0;
        chk(done && !desc_valid && !busy, "R8", "done after last", {done, desc_valid, busy}, 3'b100);
        if (inject)
            chk(warp_total == 12'(nw), "R9", "totals after ignored start", warp_total, nw);
        @(negedge clk);
        chk(!done && !busy, "R8", "done is one cycle", {done, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!desc_valid && !busy && !done, "R10", "control after reset",
            {desc_valid, busy, done}, 0);
        chk(warp_total == 0 && idle_lanes == 0, "R10", "totals after reset",
            {warp_total, idle_lanes}, 0);
        launch(0, 0, 0);        // R6
        launch(1, 30, 0);       // R5 single thread
        launch(32, 0, 0);       // R4 exact
        launch(100, 40, 0);     // R5 ragged
        launch(64, 50, 1);      // R9 injection
        launch(31, 0, 0);
        launch(33, 20, 1);
        launch(65535, 0, 0);    // maximum count
        launch(0, 0, 0);
        for (int i = 0; i < 30; i++) begin
            launch(int'($urandom % 1500), int'($urandom % 60), i % 3 == 0);
        end
        launch(96, 70, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule